// File: doc/BRIEF.md
# Compare-Match Timer with Output Modes

An 8-bit up-counting timer for a small control chip. The counter advances on ticks from a shared prescaler that divides the system clock. A compare register sets the count at which a match fires. When a match fires, the block raises a sticky flag and can act on one waveform pin.

The timer has two counting behaviours. In free-running mode the counter wraps from 255 to 0 and raises an overflow flag. In clear-on-match mode the counter returns to zero on the tick after it reaches the compare value.

A 2-bit action field picks what the pin does at each match: nothing, invert, drive low or drive high. When the field is nonzero, the timer's output replaces the ordinary port value on the pin. The pin is enabled only by its direction bit. Software uses one write port and one read port with a 3-bit register address.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, `pin_out` equals `port_val`, and `pin_oe` equals `dir_bit`.
- R2: The register addresses are 0 (control A), 1 (control B), 2 (counter), 3 (compare) and 4 (flags). Control A holds the pin action in bits 7:6, a stored second action in bits 5:4, and wave bits 1:0; its bits 3:2 always read 0. Control B holds the clock select in bits 2:0 and wave bit 2 in bit 3; its bits 7:4 read 0. The flags register holds the match flag in bit 1 and the overflow flag in bit 0. Addresses 5 to 7 read 0.
- R3: The clock select picks the tick source. Code 1 ticks on every clock. Codes 2, 3, 4 and 5 tick on clocks where a free-running divider (reset to 0, one step per clock, 10 bits) has its low 3, 6, 8 or 10 bits all ones.
- R4: Clock select codes 0, 6 and 7 stop the timer. While stopped, the counter holds its value unless software writes it.
- R5: With the wave field (control B bit 3, control A bits 1:0) at any value other than 010, a tick at count 255 takes the counter to 0 and sets the overflow flag.
- R6: With the wave field at 010, a tick at count equal to the compare value takes the counter to 0 instead of incrementing it.
- R7: A tick while the count equals the compare value sets the match flag, unless that match is blocked (R11).
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the flag ends up set.
- R9: On each unblocked match, action code 01 inverts the compare output, 10 drives it to 0 and 11 drives it to 1. Code 00 leaves it unchanged.
- R10: With a nonzero action code, `pin_out` shows the compare output. With code 00 it shows `port_val`. `pin_oe` always follows `dir_bit`.
- R11: A software write to the counter wins over a tick in the same cycle. It also blocks the match on the first tick after the write; the clear-on-match wrap still happens on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| port_val | input | 1 | Ordinary port value for the pin |
| dir_bit | input | 1 | Pin direction bit; 1 enables the driver |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
A wrong count, a wrong flag or a misapplied pin action shows up at the ports within the clock period that follows the faulty edge. A wrong flag or count appears in the next read of its register. A wrong pin action appears at once on `pin_out`. Prescaler phase errors are more subtle: they only move the tick by some cycles, so the reference divider is kept cycle-exact from reset. The count is compared on every tick of every divide ratio. Match blocking, the set-over-clear case and switching the action code back to 00 get directed checks at the exact cycles where they matter.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       port_val,
  input  logic       dir_bit,
  output logic       pin_out,
  output logic       pin_oe
);
  localparam logic [2:0] A_CTLA = 3'd0, A_CTLB = 3'd1, A_CNT = 3'd2, A_CMP = 3'd3, A_FLG = 3'd4;
  localparam logic [2:0] WAVE_CLR = 3'b010;

  logic [1:0] act_a, act_b, wave_lo;
  logic       wave_hi;
  logic [2:0] csel;
  logic [7:0] cnt, cmpv;
  logic       mflag, oflag, oc, blk;
  logic [DIV_W-1:0] pre;
  logic       tick;

  wire sel_a   = wr_en && (wr_addr == A_CTLA);
  wire sel_b   = wr_en && (wr_addr == A_CTLB);
  wire cnt_wr  = wr_en && (wr_addr == A_CNT);
  wire cmp_wr  = wr_en && (wr_addr == A_CMP);
  wire flg_wr  = wr_en && (wr_addr == A_FLG);
  wire clr_top = ({wave_hi, wave_lo} == WAVE_CLR);
  wire at_top  = (cnt == cmpv);
  wire hit     = tick && at_top && !blk && !cnt_wr;
  wire ovf_set = tick && !cnt_wr && !clr_top && (cnt == 8'hFF);

  always_comb begin
    case (csel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[DIV_W-1:0];
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0; act_b <= '0; wave_lo <= '0; wave_hi <= 1'b0; csel <= '0; cmpv <= '0;
    end else begin
      if (sel_a) {act_a, act_b, wave_lo} <= {wr_data[7:4], wr_data[1:0]};
      if (sel_b) {wave_hi, csel} <= wr_data[3:0];
      if (cmp_wr) cmpv <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= wr_data;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= (clr_top && at_top) ? 8'h00 : cnt + 8'h01;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mflag <= 1'b0;
      oflag <= 1'b0;
    end else begin
      mflag <= hit | (mflag & ~(flg_wr & wr_data[1]));
      oflag <= ovf_set | (oflag & ~(flg_wr & wr_data[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc <= 1'b0;
    else if (hit) begin
      case (act_a)
        2'b01:   oc <= ~oc;
        2'b10:   oc <= 1'b0;
        2'b11:   oc <= 1'b1;
        default: oc <= oc;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTLA:  rd_data = {act_a, act_b, 2'b00, wave_lo};
      A_CTLB:  rd_data = {4'h0, wave_hi, csel};
      A_CNT:   rd_data = cnt;
      A_CMP:   rd_data = cmpv;
      A_FLG:   rd_data = {6'h00, mflag, oflag};
      default: rd_data = 8'h00;
    endcase
  end

  assign pin_out = (act_a != 2'b00) ? oc : port_val;
  assign pin_oe  = dir_bit;

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  assert_wrap_sets_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !clr_top && cnt == 8'hFF) |=> (cnt == 8'h00 && oflag));
  assert_clear_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && clr_top && at_top) |=> (cnt == 8'h00));
  assert_flag_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mflag) |-> $past(tick));
  assert_idle_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a == 2'b00) |=> $stable(oc));
  assert_blocked_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick) |=> !$rose(mflag));
  always_comb assert_oe_follows_R10: assert (pin_oe == dir_bit);
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, port_val = 1'b0, dir_bit = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;
  wire        pin_out, pin_oe;

  cmp_timer i_cmp_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .port_val(port_val),
    .dir_bit(dir_bit), .pin_out(pin_out), .pin_oe(pin_oe));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, fix_a = -1, rot = 0;
  string cur_req = "R1";
  int m_pre;
  bit [7:0] mca, mcb, mcnt, mocr;
  bit mcf, mof, moc, mblk;

  function automatic bit [7:0] mread(int a);
    case (a)
      0: return mca;
      1: return mcb;
      2: return mcnt;
      3: return mocr;
      4: return {6'h00, mcf, mof};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; mca = 0; mcb = 0; mcnt = 0; mocr = 0; mcf = 0; mof = 0; moc = 0; mblk = 0;
    end else begin
      int n;
      bit tk, cw, ctc, sc, so;
      case (mcb[2:0])
        3'd1: n = 1; 3'd2: n = 8; 3'd3: n = 64; 3'd4: n = 256; 3'd5: n = 1024;
        default: n = 0;
      endcase
      tk = (n != 0) && ((m_pre % n) == n - 1);
      m_pre = (m_pre + 1) % 1024;
      cw = wr_en && wr_addr == 3'd2;
      ctc = ({mcb[3], mca[1:0]} == 3'b010);
      sc = 0; so = 0;
      if (cw) begin
        mcnt = wr_data; mblk = 1;
      end else if (tk) begin
        if (mcnt == mocr && !mblk) begin
          sc = 1;
          if (mca[7:6] == 2'b01) moc = !moc;
          else if (mca[7:6] == 2'b10) moc = 0;
          else if (mca[7:6] == 2'b11) moc = 1;
        end
        if (ctc && mcnt == mocr) mcnt = 0;
        else begin
          if (!ctc && mcnt == 8'hFF) so = 1;
          mcnt = mcnt + 8'd1;
        end
        mblk = 0;
      end
      if (wr_en && wr_addr == 3'd4) begin
        if (wr_data[1]) mcf = 0;
        if (wr_data[0]) mof = 0;
      end
      if (sc) mcf = 1;
      if (so) mof = 1;
      if (wr_en && wr_addr == 3'd0) mca = wr_data & 8'hF3;
      if (wr_en && wr_addr == 3'd1) mcb = wr_data & 8'h0F;
      if (wr_en && wr_addr == 3'd3) mocr = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " rd_data"}, rd_data, mread(int'(rd_addr)));
      chk("R10 pin_out", pin_out, (mca[7:6] != 0) ? moc : port_val);
      chk("R10 pin_oe", pin_oe, dir_bit);
    end
    rot = (rot + 1) % 6;
    rd_addr = (fix_a >= 0) ? 3'(fix_a) : 3'(rot);
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic peek(input int a, input string req, input int exp);
    fix_a = a;
    @(negedge clk); #1;
    chk(req, rd_data, exp);
    fix_a = -1;
    @(posedge clk); #2;
  endtask

  initial begin
    #400000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    for (int a = 0; a < 8; a++) peek(a, "R1 reset value", 0);
    port_val = 1; @(negedge clk); #1; chk("R1 pin follows port", pin_out, 1); idle(1);

    cur_req = "R2";
    wr(0, 8'hFF); peek(0, "R2 ctrl A reserved bits", 8'hF3);
    wr(1, 8'hFF); peek(1, "R2 ctrl B upper bits", 8'h0F);
    wr(1, 0); wr(0, 0);

    cur_req = "R5";
    dir_bit = 1;
    wr(3, 8'h10); wr(0, 8'h40); wr(1, 8'h01);
    idle(600);
    peek(4, "R5 overflow flag set", 3);
    cur_req = "R8";
    wr(4, 8'h00); peek(4, "R8 write zero keeps flags", 3);
    wr(4, 8'h01); peek(4, "R8 clear overflow only", 2);
    wr(4, 8'h03);

    cur_req = "R6";
    wr(1, 0); wr(2, 0); wr(3, 5); wr(0, 8'h82); wr(1, 8'h02);
    idle(300);
    wr(0, 8'hC2); idle(200);
    wr(0, 8'h42); idle(200);

    cur_req = "R3";
    for (int s = 3; s <= 5; s++) begin
      wr(1, s); idle(8 * (1 << (2 * s)));
    end
    wr(0, 8'h40); wr(3, 8'hF0);
    for (int s = 2; s <= 5; s++) begin
      wr(1, s); idle(3000);
    end

    cur_req = "R4";
    wr(1, 0);
    begin
      int held; bit [7:0] c0;
      held = 1; c0 = mcnt;
      for (int s = 0; s < 3; s++) begin
        wr(1, (s == 0) ? 0 : s + 5); idle(50);
      end
      peek(2, "R4 stopped counter holds", c0);
    end

    cur_req = "R11";
    wr(0, 8'h40); wr(3, 8'h20); wr(4, 3); wr(1, 1);
    wr(2, 8'h20); idle(1);
    wr(1, 0);
    peek(4, "R11 write blocks next-tick match", 0);
    wr(2, 8'h1F); wr(1, 1); idle(1); wr(1, 0);
    peek(4, "R7 match flag after unblocked tick", 2);

    cur_req = "R8";
    wr(4, 3); wr(3, 3); wr(2, 0); wr(0, 8'h42); wr(1, 1);
    while (mcnt != 3) idle(1);
    wr(4, 8'h02);
    peek(4, "R8 set wins over clear", 2);

    cur_req = "R9";
    wr(0, 8'h02); port_val = 0; idle(1);
    @(negedge clk); #1; chk("R9 idle code shows port", pin_out, 0); idle(1);
    port_val = 1; idle(40);
    dir_bit = 0; idle(10);
    @(negedge clk); #1; chk("R10 oe follows dir", pin_oe, 0); idle(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule